// File: doc/BRIEF.md
# Strided Load Confidence Table

This block learns, per load instruction, whether successive effective addresses advance by a constant amount. Each decoded load presents its program counter and effective address. The table is set-associative and indexed by bits of the program counter. A load with no entry gets a fresh one. A load that already has an entry computes the distance from the address it saw last time. That distance is compared with the distance the entry stored, and a small confidence counter is updated from the result.

Once the counter shows that the same distance has repeated often enough, the response carries a vectorize flag. A downstream engine can use that flag to start fetching a run of elements ahead of the scalar instances. Each response also reports hit or miss, the current stride and the confidence value. An invalidate-all input empties the table, for example on a context switch.

The table uses one synchronous-read RAM per way for the tag and data fields. Valid bits and replacement ages are kept in flops. A request is looked up on one edge and its result is registered on the next edge. A bypass path lets back-to-back requests to the same set see each other's updates.

Top module: `stride_conf_table`

## Requirements
- R1: A lookup whose tag matches no valid way in its set allocates an entry. It responds with hit 0, stride 0, confidence 0 and vectorize 0, and stores the current address as the entry's last address.
- R2: On a hit, the candidate stride is the current address minus the stored last address, modulo 2^ADDR_W. The stored last address is replaced by the current address on every access, hit or miss.
- R3: On a hit whose candidate stride equals the stored stride, confidence rises by one and saturates at 3 (2-bit counter). The reported stride is unchanged.
- R4: On a hit whose candidate stride differs from the stored stride, confidence drops to 0 and the candidate stride becomes the stored and reported stride.
- R5: The vectorize flag is 1 exactly when the confidence value after the update is 2 or more.
- R6: A request driven before rising edge k gives a response with rsp_valid 1 after rising edge k+1. A request in each consecutive cycle to the same entry sees every earlier update.
- R7: On allocation, the victim is the lowest-numbered invalid way in the set. If all ways are valid, the victim is the least recently used way. Both hits and allocations count as uses.
- R8: When inv_all is 1 at a rising edge, every entry becomes invalid at that edge. A request presented at that edge or one edge earlier is dropped, and rsp_valid is 0 after that edge.
- R9: After synchronous reset, rsp_valid is 0 and the table holds no valid entry.
- R10: The set index is req_pc[ALIGN+IDX_W-1:ALIGN], where IDX_W = log2(SETS). The tag is all remaining PC bits, including the low ALIGN bits. At most one way of a set matches a tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inv_all | input | 1 | Invalidate every entry; drops requests in flight |
| req_valid | input | 1 | A load lookup is presented |
| req_pc | input | PC_W | Program counter of the load |
| req_addr | input | ADDR_W | Effective address of the load |
| rsp_valid | output | 1 | Response is present |
| rsp_hit | output | 1 | Lookup found an existing entry |
| rsp_stride | output | ADDR_W | Stride stored after the update |
| rsp_conf | output | CONF_W | Confidence after the update |
| rsp_vec | output | 1 | Vectorize indication |

## Verification
Every response field is registered and appears two rising edges after its request. The bench drives inputs on falling edges and compares outputs on the second falling edge after the request. Its reference model is applied only when a request would leave the lookup stage, so an invalidate that drops an in-flight request also drops the model update. Directed sequences cover allocation, stride breaks, saturation, consecutive same-entry requests, eviction order and flushing. A seeded random phase mixes conflicting PCs in one set with address jumps and occasional invalidates.

// File: rtl/sct_pkg.sv
package sct_pkg;
  // Classification of one table access in the update stage.
  typedef enum logic [1:0] {
    OC_ALLOC = 2'd0,
    OC_MATCH = 2'd1,
    OC_BREAK = 2'd2
  } outcome_t;
endpackage

// File: rtl/sct_way_ram.sv
// One way of the table: synchronous read, synchronous write, no reset,
// so the array maps onto block RAM.
module sct_way_ram #(
  parameter int DEPTH = 512,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sct_lru.sv
// Per-set age ranks: 0 is most recent, WAYS-1 is the oldest.
module sct_lru #(
  parameter int SETS = 512,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [IDX_W-1:0] look_set,
  input  logic [WAYS-1:0]  vmask,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] age [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age[touch_set][w] <= '0;
        else if (age[touch_set][w] < age[touch_set][touch_way])
          age[touch_set][w] <= age[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    victim = '0;
    found  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!vmask[w] && !found) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++)
        if (age[look_set][w] == WAY_W'(WAYS-1)) victim = WAY_W'(w);
    end
  end

  // R7: the way just touched must hold the youngest rank afterwards.
  logic             chk_v;
  logic [IDX_W-1:0] chk_set;
  logic [WAY_W-1:0] chk_way;
  always_ff @(posedge clk) begin
    if (rst) chk_v <= 1'b0;
    else     chk_v <= touch_en;
    chk_set <= touch_set;
    chk_way <= touch_way;
  end

  a_r7_touched_youngest: assert property (@(posedge clk) disable iff (rst)
    chk_v |-> age[chk_set][chk_way] == '0);
endmodule

// File: rtl/sct_update.sv
// Next-state computation for one accessed entry.
module sct_update
  import sct_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CONF_W = 2,
  parameter int VEC_TH = 2
) (
  input  logic              hit,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] old_last,
  input  logic [ADDR_W-1:0] old_stride,
  input  logic [CONF_W-1:0] old_conf,
  output logic [ADDR_W-1:0] new_stride,
  output logic [CONF_W-1:0] new_conf,
  output logic              new_vec
);
  localparam logic [CONF_W-1:0] CONF_MAX = '1;

  logic [ADDR_W-1:0] diff;
  outcome_t          oc;

  assign diff = cur_addr - old_last;

  always_comb begin
    if (!hit)                    oc = OC_ALLOC;
    else if (diff == old_stride) oc = OC_MATCH;
    else                         oc = OC_BREAK;
  end

  always_comb begin
    case (oc)
      OC_MATCH: begin
        new_stride = old_stride;
        new_conf   = (old_conf == CONF_MAX) ? CONF_MAX : old_conf + 1'b1;
      end
      OC_BREAK: begin
        new_stride = diff;
        new_conf   = '0;
      end
      default: begin
        new_stride = '0;
        new_conf   = '0;
      end
    endcase
  end

  assign new_vec = (new_conf >= CONF_W'(VEC_TH));
endmodule

// File: rtl/stride_conf_table.sv
module stride_conf_table #(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int SETS   = 512,
  parameter int WAYS   = 4,
  parameter int CONF_W = 2,
  parameter int VEC_TH = 2,
  parameter int ALIGN  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inv_all,
  input  logic              req_valid,
  input  logic [PC_W-1:0]   req_pc,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [ADDR_W-1:0] rsp_stride,
  output logic [CONF_W-1:0] rsp_conf,
  output logic              rsp_vec
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = PC_W - IDX_W;
  localparam int ENT_W  = TAG_W + 2*ADDR_W + CONF_W;
  localparam int STR_LO = CONF_W;
  localparam int LST_LO = CONF_W + ADDR_W;
  localparam int TAG_LO = CONF_W + 2*ADDR_W;

  // Lookup request split into index and tag.
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  assign req_idx = req_pc[ALIGN+IDX_W-1:ALIGN];
  assign req_tag = {req_pc[PC_W-1:ALIGN+IDX_W], req_pc[ALIGN-1:0]};

  // Stage 1 registers (RAM read runs in parallel).
  logic              s1_v;
  logic [IDX_W-1:0]  s1_set;
  logic [TAG_W-1:0]  s1_tag;
  logic [ADDR_W-1:0] s1_addr;

  // Write-back path and its bypass copy.
  logic              wr_en;
  logic [WAY_W-1:0]  wr_way;
  logic [ENT_W-1:0]  wr_ent;
  logic              fwd_v;
  logic [IDX_W-1:0]  fwd_set;
  logic [WAY_W-1:0]  fwd_way;
  logic [ENT_W-1:0]  fwd_ent;

  logic [WAYS-1:0]   valid_q [SETS];
  logic [ENT_W-1:0]  rd_ent  [WAYS];
  logic [ENT_W-1:0]  cur_ent [WAYS];
  logic [WAYS-1:0]   hit_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v  <= 1'b0;
      fwd_v <= 1'b0;
    end else begin
      s1_v  <= req_valid && !inv_all;
      fwd_v <= wr_en;
    end
    s1_set  <= req_idx;
    s1_tag  <= req_tag;
    s1_addr <= req_addr;
    fwd_set <= s1_set;
    fwd_way <= wr_way;
    fwd_ent <= wr_ent;
  end

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      sct_way_ram #(.DEPTH(SETS), .DW(ENT_W)) ram_i (
        .clk   (clk),
        .we    (wr_en && (wr_way == WAY_W'(w))),
        .waddr (s1_set),
        .wdata (wr_ent),
        .raddr (req_idx),
        .rdata (rd_ent[w])
      );
      assign cur_ent[w] = (fwd_v && fwd_set == s1_set && fwd_way == WAY_W'(w))
                          ? fwd_ent : rd_ent[w];
      assign hit_vec[w] = valid_q[s1_set][w] && (cur_ent[w][TAG_LO +: TAG_W] == s1_tag);
    end
  endgenerate

  // Hit way and selected entry.
  logic             any_hit;
  logic [WAY_W-1:0] hit_way;
  logic [ENT_W-1:0] sel_ent;
  always_comb begin
    any_hit = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        any_hit = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
    sel_ent = cur_ent[hit_way];
  end

  logic [WAY_W-1:0] victim;
  sct_lru #(.SETS(SETS), .WAYS(WAYS)) lru_i (
    .clk       (clk),
    .rst       (rst),
    .touch_en  (wr_en),
    .touch_set (s1_set),
    .touch_way (wr_way),
    .look_set  (s1_set),
    .vmask     (valid_q[s1_set]),
    .victim    (victim)
  );

  logic [ADDR_W-1:0] nx_stride;
  logic [CONF_W-1:0] nx_conf;
  logic              nx_vec;
  sct_update #(.ADDR_W(ADDR_W), .CONF_W(CONF_W), .VEC_TH(VEC_TH)) upd_i (
    .hit        (any_hit),
    .cur_addr   (s1_addr),
    .old_last   (sel_ent[LST_LO +: ADDR_W]),
    .old_stride (sel_ent[STR_LO +: ADDR_W]),
    .old_conf   (sel_ent[CONF_W-1:0]),
    .new_stride (nx_stride),
    .new_conf   (nx_conf),
    .new_vec    (nx_vec)
  );

  assign wr_en  = s1_v && !inv_all;
  assign wr_way = any_hit ? hit_way : victim;
  assign wr_ent = {s1_tag, s1_addr, nx_stride, nx_conf};

  always_ff @(posedge clk) begin
    if (rst || inv_all) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (wr_en) begin
      valid_q[s1_set][wr_way] <= 1'b1;
    end
  end

  // Registered response.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_stride <= '0;
      rsp_conf   <= '0;
      rsp_vec    <= 1'b0;
    end else begin
      rsp_valid  <= wr_en;
      rsp_hit    <= any_hit;
      rsp_stride <= nx_stride;
      rsp_conf   <= nx_conf;
      rsp_vec    <= nx_vec;
    end
  end

  a_r10_single_hit: assert property (@(posedge clk) disable iff (rst)
    s1_v |-> $onehot0(hit_vec));

  a_r1_miss_clean: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_conf == '0 && rsp_stride == '0 && !rsp_vec));

  a_r5_vec_needs_hit: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_vec) |-> rsp_hit);

  a_r6_latency: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid, 2));

  a_r8_flush: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> !rsp_valid);
endmodule

// File: tb/stride_conf_table_tb_top.sv
`timescale 1ns/1ps
module stride_conf_table_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inv_all = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_pc = '0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_vec;
  logic [31:0] rsp_stride;
  logic [1:0]  rsp_conf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stride_conf_table dut_i (
    .clk(clk), .rst(rst), .inv_all(inv_all), .req_valid(req_valid),
    .req_pc(req_pc), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_stride(rsp_stride), .rsp_conf(rsp_conf),
    .rsp_vec(rsp_vec)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference model, 512 sets x 4 ways, index pc[10:2], tag = rest of pc.
  bit          m_v   [512][4];
  int unsigned m_tag [512][4];
  int unsigned m_last[512][4];
  int unsigned m_str [512][4];
  int          m_conf[512][4];
  int          m_age [512][4];

  function automatic void model_reset();
    for (int s = 0; s < 512; s++)
      for (int w = 0; w < 4; w++) begin
        m_v[s][w] = 0; m_age[s][w] = w;
      end
  endfunction

  function automatic void model_inv();
    for (int s = 0; s < 512; s++)
      for (int w = 0; w < 4; w++) m_v[s][w] = 0;
  endfunction

  function automatic void touch(int s, int w);
    int a = m_age[s][w];
    for (int k = 0; k < 4; k++)
      if (m_age[s][k] < a) m_age[s][k]++;
    m_age[s][w] = 0;
  endfunction

  bit          e_v, e_hit, e_vec;
  int unsigned e_str;
  int          e_conf;

  function automatic void model_eval(int unsigned pc, int unsigned addr);
    int s = (pc >> 2) & 511;
    int unsigned tg = ((pc >> 11) << 2) | (pc & 3);
    int w = -1;
    for (int k = 0; k < 4; k++)
      if (m_v[s][k] && m_tag[s][k] == tg) w = k;
    e_v = 1;
    if (w < 0) begin
      for (int k = 3; k >= 0; k--) if (!m_v[s][k]) w = k;
      if (w < 0) for (int k = 0; k < 4; k++) if (m_age[s][k] == 3) w = k;
      m_v[s][w] = 1; m_tag[s][w] = tg; m_str[s][w] = 0; m_conf[s][w] = 0;
      e_hit = 0;
    end else begin
      int unsigned d = addr - m_last[s][w];
      e_hit = 1;
      if (d == m_str[s][w]) begin
        if (m_conf[s][w] < 3) m_conf[s][w]++;
      end else begin
        m_str[s][w] = d; m_conf[s][w] = 0;
      end
    end
    m_last[s][w] = addr;
    e_str = m_str[s][w]; e_conf = m_conf[s][w]; e_vec = (e_conf >= 2);
    touch(s, w);
  endfunction

  // Directed single request: response is compared two falling edges later.
  task automatic dir(string req, int unsigned pc, int unsigned addr,
                     bit h, int unsigned st, int cf, bit vc);
    @(negedge clk);
    req_valid = 1; req_pc = pc; req_addr = addr;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    chk(req, "valid", rsp_valid, 1);
    chk(req, "hit", rsp_hit, h);
    chk(req, "stride", rsp_stride, st);
    chk(req, "conf", rsp_conf, cf);
    chk(req, "vec", rsp_vec, vc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned pool_pc [12];
    int unsigned nxt [12];
    int unsigned st  [12];
    bit          p_v;
    int unsigned p_pc, p_addr;
    void'($urandom(32'd4242));

    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    chk("R9", "valid after reset", rsp_valid, 0);

    // Allocation, stride learning, saturation, break (set 0, pc 0x1000).
    dir("R1", 32'h1000, 100, 0, 0, 0, 0);
    dir("R4", 32'h1000, 108, 1, 8, 0, 0);
    dir("R3", 32'h1000, 116, 1, 8, 1, 0);
    dir("R5", 32'h1000, 124, 1, 8, 2, 1);
    dir("R3", 32'h1000, 132, 1, 8, 3, 1);
    dir("R3", 32'h1000, 140, 1, 8, 3, 1);
    dir("R4", 32'h1000, 200, 1, 60, 0, 0);
    dir("R2", 32'h1000, 200, 1, 0, 0, 0);
    dir("R2", 32'h1000, 200, 1, 0, 1, 0);

    // Back-to-back same entry (set 1): updates must chain.
    @(negedge clk); req_valid = 1; req_pc = 32'h2004; req_addr = 0;
    @(negedge clk); req_addr = 4;
    @(negedge clk); req_addr = 8;
    chk("R6", "b2b0 hit", rsp_hit, 0); chk("R6", "b2b0 valid", rsp_valid, 1);
    @(negedge clk); req_addr = 12;
    chk("R6", "b2b1 stride", rsp_stride, 4); chk("R6", "b2b1 conf", rsp_conf, 0);
    @(negedge clk); req_valid = 0;
    chk("R6", "b2b2 conf", rsp_conf, 1);
    @(negedge clk);
    chk("R6", "b2b3 conf", rsp_conf, 2); chk("R5", "b2b3 vec", rsp_vec, 1);

    // Fill set 0 and evict the least recently used way.
    dir("R7", 32'h1800, 0, 0, 0, 0, 0);
    dir("R7", 32'h2000, 0, 0, 0, 0, 0);
    dir("R7", 32'h2800, 0, 0, 0, 0, 0);
    dir("R7", 32'h1000, 200, 1, 0, 2, 1);
    dir("R7", 32'h3000, 0, 0, 0, 0, 0);
    dir("R7", 32'h1000, 200, 1, 0, 3, 1);
    dir("R7", 32'h1800, 4, 0, 0, 0, 0);
    dir("R10", 32'h1001, 200, 0, 0, 0, 0);

    // Flush with a request in flight.
    @(negedge clk); req_valid = 1; req_pc = 32'h1000; req_addr = 200;
    @(negedge clk); req_valid = 0; inv_all = 1;
    @(negedge clk); inv_all = 0;
    chk("R8", "dropped response", rsp_valid, 0);
    dir("R8", 32'h1000, 200, 0, 0, 0, 0);

    // Random phase from a fresh reset, checked against the model.
    @(negedge clk) rst = 1;
    @(negedge clk) rst = 0;
    model_reset();
    for (int i = 0; i < 12; i++) begin
      pool_pc[i] = (i < 6) ? 32'h4000 + i * 32'h800 : 32'h5000 + i * 32'h404;
      nxt[i] = $urandom; st[i] = ($urandom % 4) * 4;
    end
    e_v = 0; p_v = 0;
    for (int n = 0; n < 4000; n++) begin
      bit nv, ni;
      int k;
      @(negedge clk);
      chk("R6", "rand valid", rsp_valid, e_v);
      if (e_v && rsp_valid) begin
        chk("R7", "rand hit", rsp_hit, e_hit);
        chk("R2", "rand stride", rsp_stride, e_str);
        chk("R3", "rand conf", rsp_conf, e_conf);
        chk("R5", "rand vec", rsp_vec, e_vec);
      end
      ni = (n < 3990) && ($urandom % 200 == 0);
      nv = (n < 3990) && ($urandom % 4 != 0);
      if (ni) begin
        model_inv(); e_v = 0;
      end else if (p_v) model_eval(p_pc, p_addr);
      else e_v = 0;
      k = $urandom % 12;
      if ($urandom % 10 == 0) st[k] = ($urandom % 4) * 4;
      if ($urandom % 16 == 0) nxt[k] = $urandom;
      inv_all = ni; req_valid = nv; req_pc = pool_pc[k]; req_addr = nxt[k];
      if (nv) nxt[k] += st[k];
      p_v = nv && !ni; p_pc = pool_pc[k]; p_addr = req_addr;
    end
    inv_all = 0; req_valid = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule